// File: doc/BRIEF.md
# Flash Command Decoder and Status Register

This block sits between a CPU bus and an embedded flash array. The CPU writes command bytes into the flash address range. The block decodes them, runs program and erase operations against a small array model, and decides whether a read from the flash range returns stored array bytes or a status byte. The status byte has three flags: a ready flag, a sticky erase-failure flag and a sticky program-failure flag.

Each operation is a two-write sequence. Programming is a setup byte 0x40 followed by a write of the data byte to the target address. Block erase is 0x20 followed by 0xD0 at any address inside the block. Erasing the whole array is 0x20 followed by 0x20. An operation keeps the ready flag low for a fixed, parameterised number of cycles. A fail input, sampled in the last cycle of the operation, stands in for a verify failure. While either failure flag is set, operations are refused until a clear command arrives. When an operation starts, the read path switches to status by itself.

Top module: `flash_cmd_status`

## Requirements
- R1: After synchronous reset the status byte is 0x80, the read path returns array data, every array byte reads 0xFF and rdata is 0x00.
- R2: A write of 0x70 while ready puts the read path in status mode. A read from any address then returns the status byte.
- R3: A write of 0xFF while ready puts the read path in array mode. A read then returns the byte stored at the address, or 0xFF if the location is erased.
- R4: Status byte layout: bit 7 is ready (1 idle, 0 busy), bit 5 is the erase-failure flag, bit 4 is the program-failure flag, and bits 6 and 3..0 always read 0.
- R5: The pair 0x40 then (address A, data D) programs D into A. After completion, A reads D in array mode.
- R6: The pair 0x20 then 0xD0 at address A erases the 2^BLOCK_W-byte block holding A. The erased bytes read 0xFF and the other blocks are unchanged.
- R7: The pair 0x20 then 0x20 erases every byte of the array.
- R8: The write that starts an operation makes bit 7 read 0 for exactly OP_CYCLES cycles. From that write, reads return the status byte.
- R9: If op_fail is 1 in the last busy cycle, the array is left unchanged and bit 4 (program) or bit 5 (erase) is set.
- R10: A first command byte outside {0xFF, 0x70, 0x50, 0x40, 0x20}, or an erase second byte other than 0x20 or 0xD0, sets both bit 5 and bit 4.
- R11: While bit 5 or bit 4 is 1, a program or erase sequence starts no operation. Bit 7 stays 1 and the array is unchanged.
- R12: A write of 0x50 while ready clears bits 5 and 4. The failure flags fall by no other means.
- R13: While busy, writes are ignored, except that 0xFF and 0x70 record the read mode to use when the operation ends (the last one written wins). Without either, status mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe: command or data byte on wdata |
| rd_en | input | 1 | Read strobe: rdata updates on the next edge |
| addr | input | ADDR_W | Byte address in the flash range |
| wdata | input | 8 | Write data |
| op_fail | input | 1 | Failure indication, sampled in the last busy cycle |
| rdata | output | 8 | Registered read data: array byte or status byte |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that op_fail only matters in the final busy cycle, and that the failure flags fall only in response to a clear byte on the bus. The stimulus drives at most one strobe per cycle and holds op_fail steady for a whole operation. It places busy-time writes well inside the operation, so the cycle that ends it stays free of bus traffic.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_ARRAY_MODE  = 8'hFF;
  localparam logic [7:0] CMD_STATUS_MODE = 8'h70;
  localparam logic [7:0] CMD_CLEAR_FLAGS = 8'h50;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_BLOCK_OK    = 8'hD0;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_PROG, SEQ_ERASE} seq_state_t;
  typedef enum logic [1:0] {OP_PROGRAM, OP_ERASE_BLOCK, OP_ERASE_ALL} op_kind_t;
endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int OP_CYCLES = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(OP_CYCLES + 1);
  logic [CW-1:0] remain;

  assign busy = (remain != '0);
  assign done = (remain == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)        remain <= '0;
    else if (start) remain <= CW'(OP_CYCLES);
    else if (busy)  remain <= remain - CW'(1);
  end
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BLOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  op_kind_t          op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int BLK_SIZE = 1 << BLOCK_W;
  localparam int NBLK     = 1 << (ADDR_W - BLOCK_W);
  localparam int BIDX_W   = ADDR_W - BLOCK_W;

  logic [7:0]       cells [DEPTH];
  logic [DEPTH-1:0] filled;
  logic [DEPTH-1:0] blk_mask;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign blk_mask[b*BLK_SIZE +: BLK_SIZE] =
      {BLK_SIZE{op_addr[ADDR_W-1:BLOCK_W] == BIDX_W'(b)}};
  end

  // data store has no reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (commit && op_kind == OP_PROGRAM) cells[op_addr] <= op_data;
  end

  // per-byte written flag; erase only touches these flops
  always_ff @(posedge clk) begin
    if (rst) filled <= '0;
    else if (commit) begin
      case (op_kind)
        OP_PROGRAM:     filled[op_addr] <= 1'b1;
        OP_ERASE_BLOCK: filled <= filled & ~blk_mask;
        default:        filled <= '0;
      endcase
    end
  end

  assign rd_byte = filled[rd_addr] ? cells[rd_addr] : 8'hFF;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic              done,
  input  logic              fail,
  output logic              start,
  output op_kind_t          op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              read_status,
  output logic              erase_err,
  output logic              prog_err
);
  seq_state_t state;
  op_kind_t   next_kind;
  logic       locked, set_both, pend_array, pend_next;

  assign locked = erase_err | prog_err;

  always_comb begin
    start     = 1'b0;
    next_kind = OP_PROGRAM;
    set_both  = 1'b0;
    if (wr_en && !busy) begin
      case (state)
        SEQ_PROG: start = ~locked;
        SEQ_ERASE: begin
          if (wdata == CMD_BLOCK_OK) begin
            start = ~locked; next_kind = OP_ERASE_BLOCK;
          end else if (wdata == CMD_ERASE_SETUP) begin
            start = ~locked; next_kind = OP_ERASE_ALL;
          end else set_both = 1'b1;
        end
        default:
          if (!(wdata inside {CMD_ARRAY_MODE, CMD_STATUS_MODE, CMD_CLEAR_FLAGS,
                              CMD_PROG_SETUP, CMD_ERASE_SETUP})) set_both = 1'b1;
      endcase
    end
  end

  always_comb begin
    pend_next = pend_array;
    if (wr_en && wdata == CMD_ARRAY_MODE)       pend_next = 1'b1;
    else if (wr_en && wdata == CMD_STATUS_MODE) pend_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SEQ_IDLE;
      op_kind     <= OP_PROGRAM;
      op_addr     <= '0;
      op_data     <= '0;
      read_status <= 1'b0;
      pend_array  <= 1'b0;
      erase_err   <= 1'b0;
      prog_err    <= 1'b0;
    end else if (busy) begin
      pend_array <= pend_next;
      if (done) begin
        read_status <= ~pend_next;
        if (fail) begin
          if (op_kind == OP_PROGRAM) prog_err  <= 1'b1;
          else                       erase_err <= 1'b1;
        end
      end
    end else if (wr_en) begin
      state <= SEQ_IDLE;
      if (set_both) begin
        erase_err <= 1'b1;
        prog_err  <= 1'b1;
      end
      if (start) begin
        read_status <= 1'b1;
        pend_array  <= 1'b0;
        op_kind     <= next_kind;
        op_addr     <= addr;
        op_data     <= wdata;
      end
      if (state == SEQ_IDLE) begin
        case (wdata)
          CMD_ARRAY_MODE:  read_status <= 1'b0;
          CMD_STATUS_MODE: read_status <= 1'b1;
          CMD_CLEAR_FLAGS: begin erase_err <= 1'b0; prog_err <= 1'b0; end
          CMD_PROG_SETUP:  state <= SEQ_PROG;
          CMD_ERASE_SETUP: state <= SEQ_ERASE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BLOCK_W   = 4,
  parameter int OP_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              op_fail,
  output logic [7:0]        rdata
);
  logic              busy, done, op_start, read_status, erase_err, prog_err;
  op_kind_t          op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data, array_byte, status_byte;

  flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .fail(op_fail), .start(op_start),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .read_status(read_status), .erase_err(erase_err), .prog_err(prog_err)
  );

  flash_busy_timer #(.OP_CYCLES(OP_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(op_start), .busy(busy), .done(done)
  );

  flash_array_model #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_arr (
    .clk(clk), .rst(rst), .commit(done & ~op_fail), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .rd_addr(addr), .rd_byte(array_byte)
  );

  assign status_byte = {~busy, 1'b0, erase_err, prog_err, 4'b0000};

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 8'h00;
    else if (rd_en) rdata <= read_status ? status_byte : array_byte;
  end
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int OP_CYCLES = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       busy,
  input logic       start,
  input logic       read_status,
  input logic       erase_err,
  input logic       prog_err
);
  int busy_run;
  always_ff @(posedge clk) begin
    if (rst)       busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !erase_err && !prog_err && !read_status));

  assert_locked_no_start_R11: assert property (@(posedge clk) disable iff (rst)
    start |-> (!erase_err && !prog_err));

  assert_busy_follows_start_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  assert_busy_length_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run == OP_CYCLES));

  assert_status_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> read_status);

  assert_no_start_when_busy_R13: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);

  assert_prog_flag_clear_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_err) |-> $past(wr_en && wdata == 8'h50));

  assert_erase_flag_clear_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(erase_err) |-> $past(wr_en && wdata == 8'h50));
endmodule

bind flash_cmd_status flash_cmd_checker #(.OP_CYCLES(OP_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .busy(busy),
  .start(op_start), .read_status(read_status), .erase_err(erase_err),
  .prog_err(prog_err)
);

// File: tb/tb_flash_cmd_status.sv
module tb_flash_cmd_status;
  localparam int AW = 6, BW = 4, OPN = 12, DEPTH = 1 << AW;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, op_fail = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  flash_cmd_status #(.ADDR_W(AW), .BLOCK_W(BW), .OP_CYCLES(OPN)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .op_fail(op_fail), .rdata(rdata)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference model
  logic [7:0] m_mem [DEPTH];
  bit m_valid [DEPTH];
  int m_busy, m_seq, m_kind, seqv;
  bit m_stat, m_pend, m_eerr, m_perr, m_lock;
  logic [AW-1:0] m_addr;
  logic [7:0] m_data, m_exp;

  function automatic logic [7:0] sbyte();
    return {m_busy == 0, 1'b0, m_eerr, m_perr, 4'b0};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_exp = 8'h00; m_busy = 0; m_seq = 0; m_stat = 0; m_pend = 0;
      m_eerr = 0; m_perr = 0; m_kind = 0;
      for (int i = 0; i < DEPTH; i++) m_valid[i] = 0;
    end else begin
      if (rd_en) m_exp = m_stat ? sbyte() : (m_valid[addr] ? m_mem[addr] : 8'hFF);
      if (m_busy > 0) begin
        if (wr_en && wdata == 8'hFF) m_pend = 1;
        else if (wr_en && wdata == 8'h70) m_pend = 0;
        if (m_busy == 1) begin
          if (op_fail) begin
            if (m_kind == 0) m_perr = 1; else m_eerr = 1;
          end else if (m_kind == 0) begin
            m_mem[m_addr] = m_data; m_valid[m_addr] = 1;
          end else begin
            for (int i = 0; i < DEPTH; i++)
              if (m_kind == 2 || (i >> BW) == (int'(m_addr) >> BW)) m_valid[i] = 0;
          end
          m_stat = !m_pend;
        end
        m_busy--;
      end else if (wr_en) begin
        seqv = m_seq; m_seq = 0; m_lock = m_eerr || m_perr;
        if (seqv == 1) begin
          if (!m_lock) begin m_kind = 0; m_busy = OPN; end
        end else if (seqv == 2) begin
          if (wdata == 8'hD0) begin if (!m_lock) begin m_kind = 1; m_busy = OPN; end end
          else if (wdata == 8'h20) begin if (!m_lock) begin m_kind = 2; m_busy = OPN; end end
          else begin m_eerr = 1; m_perr = 1; end
        end else begin
          case (wdata)
            8'hFF: m_stat = 0;
            8'h70: m_stat = 1;
            8'h50: begin m_eerr = 0; m_perr = 0; end
            8'h40: m_seq = 1;
            8'h20: m_seq = 2;
            default: begin m_eerr = 1; m_perr = 1; end
          endcase
        end
        if (m_busy == OPN) begin
          m_addr = addr; m_data = wdata; m_stat = 1; m_pend = 0;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (rdata !== m_exp) begin
        fails++;
        $display("FAIL %s model compare: actual %02h expected %02h", cur_req, rdata, m_exp);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc >= 100000 && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    rd_en = 1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 0;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s read @%0d: actual %02h expected %02h", req, a, rdata, exp);
    end
  endtask

  task automatic wait_ready(input string req, input bit check_len);
    int n = 0;
    rd_en = 1; addr = '0;
    @(posedge clk); @(negedge clk);
    while (rdata[7] == 1'b0 && n < 1000) begin
      n++;
      @(posedge clk); @(negedge clk);
    end
    rd_en = 0;
    if (check_len) begin
      checks++;
      if (n != OPN) begin
        fails++;
        $display("FAIL %s busy length: actual %0d expected %0d", req, n, OPN);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    checks++;
    if (rdata !== 8'h00) begin
      fails++; $display("FAIL R1 rdata after reset: actual %02h expected 00", rdata);
    end
    rd_chk(0, 8'hFF, "R1");
    rd_chk(63, 8'hFF, "R1");
    cur_req = "R2"; wr(0, 8'h70);
    rd_chk(12, 8'h80, "R2"); rd_chk(40, 8'h80, "R4");

    cur_req = "R5"; wr(0, 8'hFF);
    wr(0, 8'h40); wr(5, 8'hA5);
    cur_req = "R8"; wait_ready("R8", 1);
    rd_chk(9, 8'h80, "R8");
    cur_req = "R3"; wr(0, 8'hFF);
    rd_chk(5, 8'hA5, "R5"); rd_chk(4, 8'hFF, "R3");
    cur_req = "R5";
    wr(0, 8'h40); wr(20, 8'h3C); wait_ready("R5", 0);
    wr(0, 8'h40); wr(40, 8'h77); wait_ready("R5", 0);
    wr(0, 8'hFF);
    rd_chk(20, 8'h3C, "R5"); rd_chk(40, 8'h77, "R5");

    cur_req = "R6"; wr(0, 8'h20); wr(17, 8'hD0); wait_ready("R6", 1);
    wr(0, 8'hFF);
    rd_chk(20, 8'hFF, "R6"); rd_chk(5, 8'hA5, "R6"); rd_chk(40, 8'h77, "R6");

    cur_req = "R9"; op_fail = 1;
    wr(0, 8'h40); wr(6, 8'h12); wait_ready("R9", 1);
    op_fail = 0;
    rd_chk(0, 8'h90, "R9");
    wr(0, 8'hFF); rd_chk(6, 8'hFF, "R9");

    cur_req = "R11"; wr(0, 8'h40); wr(6, 8'h11);
    wr(0, 8'h70); rd_chk(0, 8'h90, "R11");
    wr(0, 8'h20); wr(0, 8'h20); rd_chk(0, 8'h90, "R11");
    wr(0, 8'hFF); rd_chk(6, 8'hFF, "R11"); rd_chk(5, 8'hA5, "R11");

    cur_req = "R12"; wr(0, 8'h50); wr(0, 8'h70); rd_chk(0, 8'h80, "R12");

    cur_req = "R9"; op_fail = 1;
    wr(0, 8'h20); wr(3, 8'hD0); wait_ready("R9", 0);
    op_fail = 0;
    rd_chk(0, 8'hA0, "R9");
    wr(0, 8'hFF); rd_chk(5, 8'hA5, "R9");
    cur_req = "R12"; wr(0, 8'h50); wr(0, 8'h70); rd_chk(0, 8'h80, "R12");

    cur_req = "R10"; wr(0, 8'h33); rd_chk(0, 8'hB0, "R10");
    wr(0, 8'h50); rd_chk(0, 8'h80, "R12");
    wr(0, 8'h20); wr(0, 8'h99); rd_chk(0, 8'hB0, "R10");
    wr(0, 8'h50); rd_chk(0, 8'h80, "R12");

    cur_req = "R13"; wr(0, 8'h40); wr(33, 8'h5A);
    wr(0, 8'h50); wr(0, 8'h40); wr(0, 8'hFF);
    wait_ready("R13", 0);
    rd_chk(33, 8'h5A, "R13");
    wr(0, 8'h40); wr(34, 8'h6B);
    wr(0, 8'hFF); wr(0, 8'h70);
    wait_ready("R13", 0);
    rd_chk(34, 8'h80, "R13");
    wr(0, 8'h40); wr(35, 8'h01); wr(0, 8'h20); wait_ready("R13", 0);
    rd_chk(35, 8'h80, "R13");
    wr(0, 8'hFF); rd_chk(35, 8'h01, "R13");

    cur_req = "R7"; wr(0, 8'h20); wr(0, 8'h20); wait_ready("R7", 1);
    wr(0, 8'hFF);
    rd_chk(5, 8'hFF, "R7"); rd_chk(33, 8'hFF, "R7"); rd_chk(40, 8'hFF, "R7");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule